// File: doc/BRIEF.md
# I2C Register-Write Target

This block is a bus target for I2C that accepts write transfers from a bus controller and stores the received value in a small on-chip register file. The serial clock and data lines are oversampled on the system clock through a short synchronizer. START, repeated START and STOP conditions are found on the synchronized lines. A transfer carries the 7-bit device address with a direction bit, then a register index byte, then one data byte. The target pulls SDA low through an open-drain enable to acknowledge each byte it accepts.

The register update happens in the system-clock cycle in which the SCL falling edge that closes the data byte's least significant bit is detected. A one-cycle write strobe with index and value is exported at that moment. The update does not wait for the acknowledge clock or for STOP. A hardware enable input gates the whole interface. Register 0 bit 0 is a software run bit. Clearing it has no effect on the interface and is only exported.

The controller FSM has these states: IDLE (bus free), ADDR (shift device address), ADDR_ACK, REG (shift register index), REG_ACK, DATA (shift data), DATA_ACK, and IGNORE (wait for the next START or STOP). Its transitions are:
- START moves any state to ADDR.
- STOP moves any state to IDLE.
- A low hardware enable moves any state to IDLE.
- ADDR goes to ADDR_ACK on an address match with a write bit. Otherwise it goes to IGNORE.
- Each byte state moves to its ACK state on the SCL fall after the eighth bit.
- Each ACK state moves on after the ninth SCL fall: ADDR_ACK to REG, REG_ACK to DATA, DATA_ACK to IGNORE.

Top module: `i2c_regwr_target`

## Requirements
- R1: Only a START (SDA falling while SCL is high) begins address reception. Clock pulses without a prior START are never acknowledged.
- R2: When the first byte holds the device address in bits 7..1 and bit 0 is 0, the target holds SDA low across the entire high phase of the ninth clock. It releases SDA after that clock falls.
- R3: If the address differs or bit 0 is 1 (read), SDA stays released and no register changes until the next START.
- R4: Bytes arrive MSB first, sampled on SCL rising edges. The register index byte and the data byte are each acknowledged.
- R5: The register named by the index byte takes the data byte exactly when the SCL fall after the data LSB is detected. In that cycle `wr_stb` is high for one cycle with `wr_addr` and `wr_data`. No register changes in any other cycle.
- R6: An index of NREG or above is acknowledged, but no register changes.
- R7: A START or STOP inside a byte aborts the transfer without any register write.
- R8: A repeated START at any point restarts address reception, and a complete transfer after it writes normally.
- R9: While `hw_en` is low, nothing is acknowledged and no register changes.
- R10: `sw_on` mirrors register 0 bit 0. Writes are accepted while it is 0.
- R11: Only one data byte is taken per transfer. Further bytes are neither acknowledged nor written.
- R12: After reset, all registers are 0, `sda_oe` is 0 and `wr_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Hardware enable; low disables the interface |
| scl_in | input | 1 | Serial clock line as seen on the pin |
| sda_in | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle register-write strobe |
| wr_addr | output | 8 | Register index of the write |
| wr_data | output | 8 | Value of the write |
| regs_flat | output | NREG*8 | All registers, register i at bits i*8 +: 8 |
| sw_on | output | 1 | Software run bit (register 0 bit 0) |

## Verification
Two things happen in the same clock cycle: the register commit and the entry into the data acknowledge phase. Both are triggered by the single detected SCL fall after the data LSB. The bench stops the controller model exactly at that fall. It checks that the register still holds its old value while the strobe is high. One clock later it checks that the new value and the SDA pull-down appear together. Random transfers with wrong addresses, read bits and out-of-range indices are compared against a register model kept in the bench.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } i2c_st_e;
endpackage

// File: rtl/i2c_bit_sync.sv
module i2c_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Bus conditions need SCL high in both the previous and the current sample
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regwr_fsm.sv
module i2c_regwr_fsm
    import i2c_regwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    i2c_st_e           state, nstate;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] reg_ptr;
    logic              ack_hi;
    logic              byte_full;
    logic              in_byte;
    logic              restart;

    assign byte_full = (bit_cnt == CNT_W'(BYTE_W));
    assign in_byte   = (state == ST_ADDR) || (state == ST_REG) || (state == ST_DATA);
    assign restart   = start_p || (state != nstate);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        if (!hw_en) begin
            nstate = ST_IDLE;
        end else if (start_p) begin
            nstate = ST_ADDR;
        end else if (stop_p) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nstate = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full)
                                 nstate = (shreg[7:1] == DEV_ADDR && !shreg[0])
                                          ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall && ack_hi) nstate = ST_REG;
                ST_REG:      if (scl_fall && byte_full) nstate = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall && ack_hi) nstate = ST_DATA;
                ST_DATA:     if (scl_fall && byte_full) nstate = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall && ack_hi) nstate = ST_IGNORE;
                ST_IGNORE:   nstate = ST_IGNORE;
                default:     nstate = ST_IDLE;
            endcase
        end
    end

    // Shift datapath: bit counter, shift register, index latch, ack phase flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            reg_ptr <= '0;
            ack_hi  <= 1'b0;
        end else begin
            if (state == ST_REG && nstate == ST_REG_ACK) reg_ptr <= shreg;
            if (restart) begin
                bit_cnt <= '0;
                ack_hi  <= 1'b0;
            end else begin
                if (scl_rise && in_byte && !byte_full) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                end
                if (scl_rise) ack_hi <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe  = 1'b0;
        wr_stb  = 1'b0;
        wr_addr = reg_ptr;
        wr_data = shreg;
        unique case (state)
            ST_ADDR_ACK, ST_REG_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_DATA: wr_stb = (nstate == ST_DATA_ACK);
            ST_IDLE, ST_ADDR, ST_REG, ST_IGNORE: sda_oe = 1'b0;
            default: sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_regwr_file.sv
module i2c_regwr_file
    import i2c_regwr_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic [BYTE_W-1:0]      wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            logic [BYTE_W-1:0] val;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    val <= '0;
                else if (wr_stb && wr_addr == BYTE_W'(i))
                    val <= wr_data;
            end
            assign regs_flat[i*BYTE_W +: BYTE_W] = val;
        end
    endgenerate
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
    import i2c_regwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         NREG        = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_en,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic                   wr_stb,
    output logic [7:0]             wr_addr,
    output logic [7:0]             wr_data,
    output logic [NREG*8-1:0]      regs_flat,
    output logic                   sw_on
);
    localparam int SW_REG = 0;
    localparam int SW_BIT = 0;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_p, stop_p;

    i2c_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
    );

    i2c_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
    );

    i2c_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    i2c_regwr_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p),
        .sda_oe(sda_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    i2c_regwr_file #(.NREG(NREG)) u_file (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .regs_flat(regs_flat)
    );

    assign sw_on = regs_flat[SW_REG*BYTE_W + SW_BIT];
endmodule

// File: rtl/i2c_regwr_chk.sv
module i2c_regwr_chk #(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_en,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              sda_oe,
    input logic              wr_stb,
    input logic [NREG*8-1:0] regs_flat
);
    AST_OE_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |=> !sda_oe); // R9

    AST_REGS_HELD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |=> $stable(regs_flat)); // R9

    AST_STB_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> scl_fall); // R5

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R5

    AST_REGS_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(regs_flat)); // R5

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R2
endmodule

bind i2c_regwr_target i2c_regwr_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .scl_s(scl_s),
    .scl_fall(scl_fall), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .regs_flat(regs_flat)
);

// File: tb/i2c_regwr_target_test.sv
`timescale 1ns/1ps
module i2c_regwr_target_test;
    localparam logic [6:0] DEV = 7'h2C;
    localparam int NREG = 8;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_en = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;
    logic sda_oe, wr_stb, sw_on;
    logic [7:0] wr_addr, wr_data;
    logic [NREG*8-1:0] regs_flat;
    logic [NREG*8-1:0] exp_flat = '0;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    logic [7:0] last_a, last_d;

    always #5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2c_regwr_target #(.DEV_ADDR(DEV), .NREG(NREG), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en),
        .scl_in(scl_drv), .sda_in(sda_line),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .regs_flat(regs_flat), .sw_on(sw_on)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_a = wr_addr;
            last_d = wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        if (scl_drv == 1'b0) begin
            sda_drv = 1'b1; hwait(H);
            scl_drv = 1'b1; hwait(H);
        end
        sda_drv = 1'b0; hwait(H);
        scl_drv = 1'b0; hwait(H);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; hwait(H);
        scl_drv = 1'b1; hwait(H);
        sda_drv = 1'b1; hwait(H);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; hwait(H);
        scl_drv = 1'b1; hwait(H);
        scl_drv = 1'b0; hwait(2);
    endtask

    task automatic ack_clock(output bit ack);
        logic s1, s2;
        sda_drv = 1'b1; hwait(H);
        scl_drv = 1'b1; hwait(2);
        s1 = sda_line; hwait(H-2);
        s2 = sda_line;
        scl_drv = 1'b0; hwait(2);
        ack = !s1 && !s2;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack_clock(ack);
    endtask

    function automatic bit addr_ok(input logic [6:0] d, input logic rw);
        return (d == DEV) && !rw;
    endfunction

    function automatic logic [NREG*8-1:0] model_wr(input logic [NREG*8-1:0] f, input logic [7:0] r, input logic [7:0] v);
        logic [NREG*8-1:0] n = f;
        if (r < NREG) n[r*8 +: 8] = v;
        return n;
    endfunction

    task automatic write_txn(input logic [6:0] d, input logic rw, input logic [7:0] r,
                             input logic [7:0] v, input string req);
        bit a0, a1, a2, e;
        e = addr_ok(d, rw);
        bus_start;
        send_byte({d, rw}, a0);
        send_byte(r, a1);
        send_byte(v, a2);
        bus_stop;
        chk(a0 == e, {req, " addr ack"}, a0, e);
        chk((a1 == e) && (a2 == e), {req, " reg/data ack"}, {a1, a2}, {e, e});
        if (e) exp_flat = model_wr(exp_flat, r, v);
        hwait(4);
        chk(regs_flat == exp_flat, {req, " regs"}, regs_flat, exp_flat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a, b;
        int s0;
        void'($urandom(32'h5EED));
        hwait(3);
        // R12 reset state
        chk(regs_flat == '0 && !sda_oe && !wr_stb, "R12 reset", {sda_oe, wr_stb}, 0);
        rst_n = 1'b1;
        hwait(3);

        // R1 byte without START is ignored
        send_byte({DEV, 1'b0}, a);
        chk(!a, "R1 no start no ack", a, 0);
        scl_drv = 1'b1; sda_drv = 1'b1; hwait(H);

        // R2 R4 basic write
        write_txn(DEV, 1'b0, 8'd3, 8'hA5, "R2 R4 basic");

        // R5 commit at the data-LSB SCL fall, same cycle as ACK entry
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd6, b);
        for (int i = 7; i >= 1; i--) send_bit(1'(8'h3C >> i));
        sda_drv = 1'b0; hwait(H);
        scl_drv = 1'b1; hwait(H);
        s0 = stb_cnt;
        chk(regs_flat[6*8 +: 8] == 8'h00 && stb_cnt == s0, "R5 before fall", regs_flat[6*8 +: 8], 0);
        scl_drv = 1'b0; hwait(2);
        chk(wr_stb && regs_flat[6*8 +: 8] == 8'h00, "R5 strobe at fall", {wr_stb, regs_flat[6*8 +: 8]}, 9'h100);
        chk(wr_addr == 8'd6 && wr_data == 8'h3C, "R5 strobe fields", {wr_addr, wr_data}, 16'h063C);
        hwait(1);
        chk(regs_flat[6*8 +: 8] == 8'h3C && sda_oe && !wr_stb, "R5 commit with ack", {sda_oe, regs_flat[6*8 +: 8]}, 9'h13C);
        exp_flat = model_wr(exp_flat, 8'd6, 8'h3C);
        ack_clock(a);
        chk(a, "R4 data ack", a, 1);
        // R11 extra byte
        s0 = stb_cnt;
        send_byte(8'hFF, b);
        bus_stop;
        hwait(4);
        chk(!b && stb_cnt == s0, "R11 second data byte", b, 0);
        chk(regs_flat == exp_flat, "R11 regs", regs_flat, exp_flat);

        // R3 mismatch and read bit
        write_txn(DEV ^ 7'h01, 1'b0, 8'd1, 8'h11, "R3 wrong addr");
        write_txn(DEV, 1'b1, 8'd1, 8'h22, "R3 read bit");

        // R6 out of range index
        write_txn(DEV, 1'b0, 8'd9, 8'h77, "R6 out of range");

        // R7 STOP mid-byte
        s0 = stb_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd2, b);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop;
        hwait(4);
        chk(stb_cnt == s0 && regs_flat == exp_flat, "R7 stop mid byte", regs_flat, exp_flat);
        // R7 R8 START mid-byte then full transfer after it
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd2, b);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd5, b);
        send_byte(8'hC3, a);
        bus_stop;
        exp_flat = model_wr(exp_flat, 8'd5, 8'hC3);
        hwait(4);
        chk(a && b && regs_flat == exp_flat, "R8 restart after mid-byte start", regs_flat, exp_flat);
        // R8 repeated START after index byte
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd4, b);
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd7, b);
        send_byte(8'h5E, a);
        bus_stop;
        exp_flat = model_wr(exp_flat, 8'd7, 8'h5E);
        hwait(4);
        chk(regs_flat == exp_flat, "R8 repeated start", regs_flat, exp_flat);

        // R9 hardware disable
        hw_en = 1'b0;
        write_txn(DEV ^ 7'h7F, 1'b0, 8'd2, 8'hEE, "R9 disabled");
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd2, b);
        bus_stop;
        hwait(4);
        chk(!a && !b && regs_flat == exp_flat, "R9 no ack no write", {a, b}, 0);
        hw_en = 1'b1;
        hwait(4);

        // R10 software run bit cleared keeps interface alive
        write_txn(DEV, 1'b0, 8'd0, 8'h00, "R10 clear run");
        chk(!sw_on, "R10 sw_on low", sw_on, 0);
        write_txn(DEV, 1'b0, 8'd2, 8'h5A, "R10 write while off");
        write_txn(DEV, 1'b0, 8'd0, 8'h01, "R10 set run");
        chk(sw_on, "R10 sw_on high", sw_on, 1);

        // random mix
        for (int k = 0; k < 30; k++) begin
            logic [6:0] d;
            logic rw;
            logic [7:0] r, v;
            d  = ($urandom % 4 != 0) ? DEV : 7'($urandom);
            rw = ($urandom % 5 == 0);
            r  = 8'($urandom % 12);
            v  = 8'($urandom);
            write_txn(d, rw, r, v, "R2 R3 R4 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule